// File: doc/BRIEF.md
# Cubic Lagrange Fractional Resampler

This block converts a stream of signed samples arriving at one rate into a stream at a different rate. The conversion ratio is the output period divided by the input period. For every output, a third-order Lagrange polynomial is fitted through four neighbouring input samples. The polynomial is then evaluated at a fractional position mu, which lies between the second and third of those samples. The polynomial is evaluated in Farrow form: four coefficients come from the samples, and the result is formed by Horner's rule in mu.

A phase accumulator adds the ratio to mu once per output. The integer carry out of that sum tells the block how many fresh input samples to take into its four-entry history before the next output. A carry of zero repeats the history, which is upsampling. A carry of two or more skips samples, which is downsampling. The ratio can be reloaded at any time and the fractional phase is never cleared. A change of input clock domain therefore continues from the accumulated phase, with no timing jump. Inputs arrive on a valid/ready stream, and outputs leave on a valid-only stream.

Top module: `lagrange_resampler`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the ratio register holds 1.0, and the phase is zero. The first output is computed only after four input samples have been accepted.
- R2: An input sample is accepted in a cycle where in_valid and in_ready are both high. in_ready is high exactly while the block still owes input samples before its next output. The four-sample history changes only on an accepted sample.
- R3: The ratio is an unsigned fixed-point word with 4 integer bits above 20 fractional bits (value = word / 2^20). Each output adds the ratio to the 20-bit fractional phase. The carry becomes the count of samples to accept before the next output. A carry of zero lets the next output be computed in the very next cycle from the same history.
- R4: ratio_load with ratio_in replaces the ratio and never clears the phase. When the load falls in a cycle where an output is being computed, the new ratio already sets that output's phase advance.
- R5: mu is the upper 16 bits of the fractional phase, read as mu/65536. The output is the cubic Lagrange interpolant through the samples at positions −1, 0, +1, +2, evaluated at mu (0 ≤ mu < 1) past the sample at position 0. It stays within 2 LSB of the real-valued result.
- R6: With mu equal to zero, the output equals the position-0 sample exactly. For a linear ramp input, every output equals the ramp value at its position.
- R7: Results are rounded to the nearest integer and saturated to the 16-bit signed range.
- R8: Each output appears on out_data with out_valid high for one cycle, one clock after the cycle in which it is computed. At most one output is produced per cycle.
- R9: With a ratio of 0.75 from phase zero, mu runs 0, 0.75, 0.5, 0.25, 0. Loading 1.5 at the output where mu returns to 0 continues with 0.5, 0, 0.5, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block takes an input sample this cycle |
| in_data | input | 16 | Signed input sample |
| ratio_in | input | 24 | New ratio, 4 integer and 20 fractional bits |
| ratio_load | input | 1 | Capture ratio_in |
| out_valid | output | 1 | Output sample present |
| out_data | output | 16 | Signed, rounded, saturated output sample |

## Verification
Two events can fall in the same cycle: a ratio load and the computation of an output. The bench provokes this on a linear ramp by loading 1.5 exactly in the cycle that computes the fifth output (mu = 0). The new ratio must already govern the advance to the sixth output. It then judges the outputs against the ramp values at positions 5.5, 7, 8.5 and 10. Any slip in which ratio applies, and any reset of the phase, moves those positions. Random loads, some landing on computing cycles and some on waiting cycles, are also followed by the per-cycle reference model.

// File: rtl/lgr_pkg.sv
package lgr_pkg;
  localparam int LGR_DW    = 16;
  localparam int LGR_RI    = 4;
  localparam int LGR_RF    = 20;
  localparam int LGR_MUW   = 16;
  localparam int LGR_NTAP  = 4;
endpackage

// File: rtl/lgr_phase_acc.sv
module lgr_phase_acc #(
  parameter int RI  = 4,
  parameter int RF  = 20,
  parameter int MUW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             ratio_load,
  input  logic [RI+RF-1:0] ratio,
  output logic [MUW-1:0]   mu,
  output logic [RI:0]      advance
);
  localparam int RW = RI + RF;

  logic [RF-1:0] frac;
  logic [RW:0]   sum;

  assign sum     = {{(RI+1){1'b0}}, frac} + {1'b0, ratio};
  assign advance = sum[RW:RF];
  assign mu      = frac[RF-1 -: MUW];

  always_ff @(posedge clk) begin
    if (rst)       frac <= '0;
    else if (step) frac <= sum[RF-1:0];
  end

  // a load on its own leaves the phase untouched
  assert_phase_kept_on_load_R4: assert property (@(posedge clk) disable iff (rst)
    (ratio_load && !step) |=> (frac == $past(frac)));

  // a whole-number ratio moves no fractional phase
  assert_integer_ratio_keeps_phase_R3: assert property (@(posedge clk) disable iff (rst)
    (step && ratio[RF-1:0] == '0) |=> $stable(frac));
endmodule

// File: rtl/lgr_tap_line.sv
module lgr_tap_line #(
  parameter int DW   = 16,
  parameter int NTAP = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      shift,
  input  logic [DW-1:0]             din,
  output logic [NTAP-1:0][DW-1:0]   taps
);
  always_ff @(posedge clk) begin
    if (rst)        taps[0] <= '0;
    else if (shift) taps[0] <= din;
  end

  for (genvar i = 1; i < NTAP; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)        taps[i] <= '0;
      else if (shift) taps[i] <= taps[i-1];
    end
  end

  assert_taps_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(taps));
endmodule

// File: rtl/lgr_farrow.sv
module lgr_farrow #(
  parameter int DW  = 16,
  parameter int MUW = 16
) (
  input  logic [MUW-1:0]       mu,
  input  logic signed [DW-1:0] xm1,
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  output logic signed [DW-1:0] y
);
  localparam int AW = DW + 8;
  localparam int PW = AW + MUW + 1;
  localparam logic signed [AW-1:0] SIX   = AW'(6);
  localparam logic signed [AW-1:0] THREE = AW'(3);
  localparam logic signed [AW-1:0] MAXV  = AW'((1 << (DW-1)) - 1);
  localparam logic signed [AW-1:0] MINV  = -MAXV - AW'(1);

  logic signed [AW-1:0] a, b, c, d;
  logic signed [AW-1:0] k1, k2, k3, t2, t1, y6, mag, qm, q;
  logic signed [PW-1:0] mus, p3, p2, p1;

  // coefficients are kept scaled by 6 so no fraction is lost before Horner
  always_comb begin
    a  = AW'(xm1);
    b  = AW'(x0);
    c  = AW'(x1);
    d  = AW'(x2);
    k1 = (c <<< 2) + (c <<< 1) - (a <<< 1) - ((b <<< 1) + b) - d;
    k2 = ((a <<< 1) + a) + ((c <<< 1) + c) - ((b <<< 2) + (b <<< 1));
    k3 = d - a + ((b <<< 1) + b) - ((c <<< 1) + c);
    mus = PW'($signed({1'b0, mu}));
    p3  = PW'(k3) * mus;
    t2  = k2 + AW'(p3 >>> MUW);
    p2  = PW'(t2) * mus;
    t1  = k1 + AW'(p2 >>> MUW);
    p1  = PW'(t1) * mus;
    y6  = (b <<< 2) + (b <<< 1) + AW'(p1 >>> MUW);
    mag = y6[AW-1] ? -y6 : y6;
    qm  = (mag + THREE) / SIX;
    q   = y6[AW-1] ? -qm : qm;
    if (q > MAXV)      y = MAXV[DW-1:0];
    else if (q < MINV) y = MINV[DW-1:0];
    else               y = q[DW-1:0];
  end
endmodule

// File: rtl/lagrange_resampler.sv
module lagrange_resampler
  import lgr_pkg::*;
#(
  parameter int DW  = LGR_DW,
  parameter int RI  = LGR_RI,
  parameter int RF  = LGR_RF,
  parameter int MUW = LGR_MUW,
  parameter logic [RI+RF-1:0] RESET_RATIO = (RI+RF)'(1) << RF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [RI+RF-1:0]  ratio_in,
  input  logic              ratio_load,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  localparam int RW   = RI + RF;
  localparam int NTAP = LGR_NTAP;
  localparam int CW   = (RI + 1 > 3) ? RI + 1 : 3;

  logic [RW-1:0]            ratio_q, ratio_eff;
  logic [CW-1:0]            pend;
  logic                     fire, accept;
  logic [MUW-1:0]           mu;
  logic [RI:0]              advance;
  logic [NTAP-1:0][DW-1:0]  taps;
  logic signed [DW-1:0]     y;

  assign ratio_eff = ratio_load ? ratio_in : ratio_q;
  assign fire      = (pend == '0);
  assign in_ready  = !fire;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)             ratio_q <= RESET_RATIO;
    else if (ratio_load) ratio_q <= ratio_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         pend <= CW'(NTAP);
    else if (fire)   pend <= CW'(advance);
    else if (accept) pend <= pend - CW'(1);
  end

  lgr_phase_acc #(.RI(RI), .RF(RF), .MUW(MUW)) u_phase (
    .clk(clk), .rst(rst), .step(fire), .ratio_load(ratio_load),
    .ratio(ratio_eff), .mu(mu), .advance(advance)
  );

  lgr_tap_line #(.DW(DW), .NTAP(NTAP)) u_taps (
    .clk(clk), .rst(rst), .shift(accept), .din(in_data), .taps(taps)
  );

  // taps[0] is the newest sample (position +2), taps[3] the oldest (position -1)
  lgr_farrow #(.DW(DW), .MUW(MUW)) u_farrow (
    .mu(mu), .xm1($signed(taps[3])), .x0($signed(taps[2])),
    .x1($signed(taps[1])), .x2($signed(taps[0])), .y(y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= y;
    end
  end

  assert_center_sample_R6: assert property (@(posedge clk) disable iff (rst)
    (fire && mu == '0) |=> (out_data == $past(taps[2])));
endmodule

// File: tb/lagrange_resampler_test.sv
module lagrange_resampler_test;
  localparam int CLK_PERIOD = 10;
  localparam int ONE = 1 << 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic [23:0] ratio_in = '0;
  logic ratio_load = 1'b0;
  logic out_valid;
  logic signed [15:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int m_pend, m_frac, m_ratio, nfire;
  int hist[4];
  bit m_acc_last;
  int got[$];

  lagrange_resampler uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .ratio_in(ratio_in), .ratio_load(ratio_load),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd_sat(real r);
    real f;
    f = (r >= 0.0) ? $floor(r + 0.5) : -$floor(-r + 0.5);
    if (f > 32767.0) return 32767;
    if (f < -32768.0) return -32768;
    return int'(f);
  endfunction

  function automatic real lag(real a, real b, real c, real d, real m);
    return -a * m * (m - 1.0) * (m - 2.0) / 6.0
         +  b * (m + 1.0) * (m - 1.0) * (m - 2.0) / 2.0
         -  c * (m + 1.0) * m * (m - 2.0) / 2.0
         +  d * (m + 1.0) * m * (m - 1.0) / 6.0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; ratio_load = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_pend = 4; m_frac = 0; m_ratio = ONE; nfire = 0;
    foreach (hist[i]) hist[i] = 0;
    got.delete();
    #1;
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
  endtask

  // one clock: drive at negedge, predict, compare registered outputs at next negedge
  task automatic tick(bit v, int d, bit ld, int r);
    bit fire, acc, ev;
    int ed, s;
    real mu;
    in_valid = v; in_data = 16'(d); ratio_load = ld; ratio_in = 24'(r);
    #1;
    chk(in_ready == (m_pend != 0), "R2 in_ready", in_ready, m_pend != 0);
    fire = (m_pend == 0);
    acc = v && (m_pend != 0);
    ev = 0; ed = 0;
    if (fire) begin
      mu = real'(m_frac >> 4) / 65536.0;
      ed = rnd_sat(lag(real'(hist[3]), real'(hist[2]), real'(hist[1]), real'(hist[0]), mu));
      ev = 1;
      s = m_frac + (ld ? r : m_ratio);
      m_pend = s >> 20;
      m_frac = s & (ONE - 1);
      nfire++;
    end
    if (acc) begin
      hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = d;
      m_pend--;
    end
    if (ld) m_ratio = r;
    m_acc_last = acc;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == ev, "R8 out_valid timing", out_valid, ev);
    if (ev && out_valid) begin
      chk((int'(out_data) - ed <= 2) && (ed - int'(out_data) <= 2),
          "R5 value vs real cubic model", out_data, ed);
      got.push_back(int'(out_data));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int idx, guard;
    int exp_seq[9] = '{1000, 1750, 2500, 3250, 4000, 5500, 7000, 8500, 10000};
    int rl[6] = '{524288, 2883584, 1048576, 1398101, 314573, 4089446};

    // R1 / R9 / R4 / R6: ramp with ratio 0.75 then 1.5 loaded on a computing cycle
    do_reset();
    tick(1, 0, 1, 786432);
    tick(1, 1000, 0, 0);
    tick(1, 2000, 0, 0);
    for (int k = 0; k < 2; k++) begin
      tick(0, 0, 0, 0);
      chk(out_valid == 1'b0, "R1 no output before four inputs", out_valid, 0);
      chk(in_ready == 1'b1, "R1 still requesting input", in_ready, 1);
    end
    idx = 3; guard = 0;
    while (got.size() < 9 && guard < 200) begin
      bit ld;
      ld = (m_pend == 0) && (nfire == 4);
      tick(1, idx * 1000, ld, 1572864);
      if (m_acc_last) idx++;
      guard++;
    end
    chk(got.size() == 9, "R9 ramp output count", got.size(), 9);
    if (got.size() >= 9) begin
      chk(got[0] == 1000, "R6 mu zero gives centre sample", got[0], 1000);
      chk(got[4] == 4000, "R6 mu zero after wrap", got[4], 4000);
      for (int i = 0; i < 9; i++)
        chk(got[i] == exp_seq[i], "R9 mu sequence across ratio switch (R4 phase kept)", got[i], exp_seq[i]);
    end

    // R7: positive overshoot saturates
    do_reset();
    tick(1, -32768, 1, 524288);
    tick(1, 32767, 0, 0);
    tick(1, 32767, 0, 0);
    tick(1, -32768, 0, 0);
    for (int k = 0; k < 3; k++) tick(0, 0, 0, 0);
    chk(got.size() >= 2, "R3 two outputs from one history at ratio 0.5", got.size(), 2);
    if (got.size() >= 2) begin
      chk(got[0] == 32767, "R6 centre sample", got[0], 32767);
      chk(got[1] == 32767, "R7 saturate high", got[1], 32767);
    end

    // R7: negative overshoot saturates
    do_reset();
    tick(1, 32767, 1, 524288);
    tick(1, -32768, 0, 0);
    tick(1, -32768, 0, 0);
    tick(1, 32767, 0, 0);
    for (int k = 0; k < 3; k++) tick(0, 0, 0, 0);
    if (got.size() >= 2)
      chk(got[1] == -32768, "R7 saturate low", got[1], -32768);
    else
      chk(0, "R7 saturate low output missing", got.size(), 2);

    // R3 / R4 / R5: random data, gaps and run-time ratio changes
    do_reset();
    for (int k = 0; k < 900; k++) begin
      bit ld;
      int r;
      ld = (($urandom % 50) == 0) || ((m_pend == 0) && (($urandom % 30) == 0));
      r = rl[$urandom % 6];
      tick(($urandom % 4) != 0, int'($urandom % 65536) - 32768, ld, r);
    end
    chk(nfire > 100, "R3 outputs produced under random ratios", nfire, 100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule